// File: doc/BRIEF.md
# Normalised Piecewise-Linear Inverse Square Root

This unit takes a 16-bit unsigned operand X and returns a fixed-point estimate of 2^22 / sqrt(X). First a serial normaliser moves the operand left two bits per cycle until its top pair of bits is not 00. This brings every nonzero operand into the quarter-range 16384..65535, where the curve is only mildly nonlinear. The normalised word then picks one segment of a 64-entry endpoint table and is interpolated linearly between the two neighbouring endpoints. The product is formed by a serial shift-and-add multiplier. A serial shifter then scales the value back to the original operand.

The table endpoints are exact integer square-root results computed while the design is elaborated. No file or memory load is involved. The table is evaluated at 2^29 / sqrt(N) for the normalised word N. The final right shift, by the number of two-bit steps the normaliser did not need, turns that into 2^22 / sqrt(X).

The block uses a start/done handshake. A zero operand is caught in the first normalisation cycle and answered at once with a saturated result and a flag.

Top module: `irt_inverse_root`

## Requirements
- R1: While reset is held and after its release, `done`, `zero` and `result` are 0 until the first operation completes.
- R2: `done` is high for exactly one cycle per accepted operation. `result` and `zero` keep their values from that cycle until the next completion.
- R3: Normalisation shifts the operand left by two bits per cycle until its top two bits are not 00, using at most 7 shifts. Bits [15:10] of the normalised word (value 16..63) select the segment, and bits [9:0] are the interpolation fraction.
- R4: For a nonzero operand, `done` is high in the 20th cycle after the clock edge that accepted `start`, whatever the operand.
- R5: For every X in 1..65535, the 23-bit unsigned `result` is within a relative error of 2^-10 of 2^22 / sqrt(X).
- R6: For X = 0, `done` is high in the cycle after the accepting edge, with `zero` = 1 and `result` = all ones (8388607).
- R7: A `start` that arrives while an operation is in flight is ignored: it changes neither the running result nor its timing, and it causes no second completion.
- R8: Every completion for a nonzero operand has `zero` = 0, including one that directly follows a zero operand.
- R9: When 4X <= 65535, result(4X) equals result(X) shifted right by one bit, exactly.
- R10: For X = 4^j (j = 0..7), `result` is exactly 2^(22-j).
- R11: A `start` sampled in the same cycle that `done` is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation on `x_in` when the unit is idle |
| x_in | input | 16 | Unsigned operand, sampled with `start` |
| done | output | 1 | One-cycle completion pulse |
| result | output | 23 | Unsigned estimate of 2^22 / sqrt(X); all ones for zero |
| zero | output | 1 | Set at completion when the operand was zero |

## Verification
Two events can land on the same clock edge: the completion of one operation and the acceptance of the next `start`. The bench issues its next operand in the very cycle it sees `done`, so nearly every operation in its sweeps begins on a completion edge. Each of these operations is judged on its real-valued accuracy, its 20-cycle latency and its `zero` flag. A second collision, a `start` that arrives mid-computation, is judged by an exact power-of-four result, an unchanged latency and the absence of any later completion.

// File: rtl/irt_pkg.sv
// Shared definitions for the inverse-root unit: the control state encoding
// and the elaboration-time functions that compute the segment endpoints.
// Assumes 64-bit integer arithmetic at elaboration and endpoint exponents
// below 64.
package irt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_NORM,
        ST_MUL,
        ST_DENORM
    } irt_state_e;

    // Integer square root by bit-by-bit trial, floor result.
    function automatic logic [63:0] isqrt64(input logic [63:0] n);
        logic [63:0] r;
        logic [63:0] t;
        r = '0;
        for (int b = 31; b >= 0; b--) begin
            t = r | (64'd1 << b);
            if (t * t <= n) r = t;
        end
        return r;
    endfunction

    // Endpoint at segment boundary idx: floor(sqrt(2^num_exp / idx)).
    function automatic logic [63:0] seg_endpoint(input int idx, input int num_exp);
        if (idx == 0) return '1;
        return isqrt64((64'd1 << num_exp) / 64'(idx));
    endfunction

endpackage

// File: rtl/irt_norm.sv
// Serial operand normaliser. On load it captures the operand; each later
// cycle it shifts left by two bits while the top pair is 00, counting steps.
// It flags completion as soon as the top pair is nonzero or the word is zero.
// Assumes a nonzero operand needs at most MAX_STEPS shifts.
module irt_norm #(
    parameter int IN_W      = 16,
    parameter int MAX_STEPS = 7,
    parameter int STEP_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [IN_W-1:0]   x_in,
    output logic              finished,
    output logic              is_zero,
    output logic [IN_W-1:0]   norm_val,
    output logic [STEP_W-1:0] steps
);

    logic [IN_W-1:0]   val_q;
    logic [STEP_W-1:0] cnt_q;
    logic              act_q;
    logic              top_pair_clear;

    // Purpose: combinational view of the working word.
    always_comb begin
        top_pair_clear = (val_q[IN_W-1 -: 2] == 2'b00);
        is_zero        = (val_q == '0);
        finished       = act_q && (!top_pair_clear || is_zero);
        norm_val       = val_q;
        steps          = cnt_q;
    end

    // Purpose: capture, then shift two bits per cycle until normalised.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            val_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            act_q <= 1'b1;
            val_q <= x_in;
            cnt_q <= '0;
        end else if (act_q) begin
            if (finished) begin
                act_q <= 1'b0;
            end else begin
                val_q <= val_q << 2;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_NORM_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        act_q && (cnt_q == STEP_W'(MAX_STEPS)) |-> finished); // R3

endmodule

// File: rtl/irt_seg_table.sv
// Constant endpoint table: entry g holds floor(sqrt(2^NUM_EXP / g)), which is
// 2^(NUM_EXP/2) / sqrt(g). It returns the two endpoints that bound segment idx.
// Entries below a quarter of the table are never addressed by normalised words.
module irt_seg_table #(
    parameter int SEG_BITS = 6,
    parameter int RES_W    = 23,
    parameter int NUM_EXP  = 48
) (
    input  logic [SEG_BITS-1:0] idx,
    output logic [RES_W-1:0]    ep_lo,
    output logic [RES_W-1:0]    ep_hi
);

    localparam int SEGS = 1 << SEG_BITS;

    logic [RES_W-1:0]  tab [SEGS+1];
    logic [SEG_BITS:0] idx_lo;
    logic [SEG_BITS:0] idx_hi;

    for (genvar g = 0; g <= SEGS; g++) begin : g_ep
        localparam logic [RES_W-1:0] EP = RES_W'(irt_pkg::seg_endpoint(g, NUM_EXP));
        assign tab[g] = EP;
    end

    // Purpose: select the segment's lower and upper endpoints.
    always_comb begin
        idx_lo = {1'b0, idx};
        idx_hi = {1'b0, idx} + 1'b1;
        ep_lo  = tab[idx_lo];
        ep_hi  = tab[idx_hi];
    end

endmodule

// File: rtl/irt_interp.sv
// Serial linear interpolator: y = base - floor(diff * frac / 2^FRAC_W).
// The product is built by shift-and-add, one multiplier bit per cycle.
// ready rises FRAC_W cycles after load. Assumes diff <= base.
module irt_interp #(
    parameter int RES_W  = 23,
    parameter int FRAC_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [RES_W-1:0]  base_in,
    input  logic [RES_W-1:0]  diff_in,
    input  logic [FRAC_W-1:0] frac_in,
    output logic              ready,
    output logic [RES_W-1:0]  y_out
);

    localparam int ACC_W = RES_W + FRAC_W;
    localparam int CNT_W = $clog2(FRAC_W + 1);

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  mcand_q;
    logic [FRAC_W-1:0] mplier_q;
    logic [RES_W-1:0]  base_q;
    logic [RES_W-1:0]  diff_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              act_q;
    logic [RES_W-1:0]  drop;

    // Purpose: completion flag and final subtraction.
    always_comb begin
        ready = act_q && (cnt_q == '0);
        drop  = acc_q[ACC_W-1:FRAC_W];
        y_out = base_q - drop;
    end

    // Purpose: one shift-and-add step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            base_q   <= '0;
            diff_q   <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            act_q    <= 1'b1;
            acc_q    <= '0;
            mcand_q  <= ACC_W'(diff_in);
            mplier_q <= frac_in;
            base_q   <= base_in;
            diff_q   <= diff_in;
            cnt_q    <= CNT_W'(FRAC_W);
        end else if (act_q) begin
            if (cnt_q != '0) begin
                if (mplier_q[0]) acc_q <= acc_q + mcand_q;
                mcand_q  <= mcand_q << 1;
                mplier_q <= mplier_q >> 1;
                cnt_q    <= cnt_q - 1'b1;
            end else begin
                act_q <= 1'b0;
            end
        end
    end

    AST_DROP_IN_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (drop <= diff_q)); // R5

endmodule

// File: rtl/irt_inverse_root.sv
// Inverse square-root unit: result = 2^RES_SCALE / sqrt(x_in).
// Phases: serial normalise, table lookup with serial linear interpolation,
// then a serial right shift by the normalisation steps not taken. A zero
// operand finishes after one normalise cycle with a saturated result.
// start is honoured only while idle; the latency is constant for nonzero input.
module irt_inverse_root #(
    parameter int IN_W      = 16,
    parameter int SEG_BITS  = 6,
    parameter int RES_SCALE = 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [IN_W-1:0]      x_in,
    output logic                 done,
    output logic [RES_SCALE:0]   result,
    output logic                 zero
);
    import irt_pkg::*;

    localparam int MAX_STEPS = IN_W / 2 - 1;
    localparam int STEP_W    = $clog2(MAX_STEPS + 1);
    localparam int FRAC_W    = IN_W - SEG_BITS;
    localparam int RES_W     = RES_SCALE + 1;
    localparam int NUM_EXP   = 2 * (RES_SCALE + MAX_STEPS) - FRAC_W;
    localparam int LATENCY   = MAX_STEPS + FRAC_W + 3;
    localparam int LAT_W     = $clog2(LATENCY + 1) + 1;

    irt_state_e          st_q;
    logic                nrm_load;
    logic                nrm_fin;
    logic                nrm_zero;
    logic [IN_W-1:0]     nrm_val;
    logic [STEP_W-1:0]   nrm_steps;
    logic [SEG_BITS-1:0] seg_idx;
    logic [FRAC_W-1:0]   seg_frac;
    logic [RES_W-1:0]    ep_lo;
    logic [RES_W-1:0]    ep_hi;
    logic [RES_W-1:0]    ep_diff;
    logic                mul_load;
    logic                mul_ready;
    logic [RES_W-1:0]    mul_y;
    logic [RES_W-1:0]    sh_q;
    logic [STEP_W-1:0]   shcnt_q;
    logic                done_q;
    logic                zero_q;
    logic [RES_W-1:0]    res_q;
    logic [LAT_W-1:0]    lat_q;

    // Purpose: hand-off strobes and segment decode of the normalised word.
    always_comb begin
        nrm_load = (st_q == ST_IDLE) && start;
        mul_load = (st_q == ST_NORM) && nrm_fin && !nrm_zero;
        seg_idx  = nrm_val[IN_W-1 -: SEG_BITS];
        seg_frac = nrm_val[FRAC_W-1:0];
        ep_diff  = ep_lo - ep_hi;
    end

    irt_norm #(
        .IN_W      (IN_W),
        .MAX_STEPS (MAX_STEPS),
        .STEP_W    (STEP_W)
    ) u_norm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (nrm_load),
        .x_in     (x_in),
        .finished (nrm_fin),
        .is_zero  (nrm_zero),
        .norm_val (nrm_val),
        .steps    (nrm_steps)
    );

    irt_seg_table #(
        .SEG_BITS (SEG_BITS),
        .RES_W    (RES_W),
        .NUM_EXP  (NUM_EXP)
    ) u_table (
        .idx   (seg_idx),
        .ep_lo (ep_lo),
        .ep_hi (ep_hi)
    );

    irt_interp #(
        .RES_W  (RES_W),
        .FRAC_W (FRAC_W)
    ) u_interp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (mul_load),
        .base_in (ep_lo),
        .diff_in (ep_diff),
        .frac_in (seg_frac),
        .ready   (mul_ready),
        .y_out   (mul_y)
    );

    // Purpose: phase sequencing, denormalising shift and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            sh_q    <= '0;
            shcnt_q <= '0;
            done_q  <= 1'b0;
            zero_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) st_q <= ST_NORM;
                end
                ST_NORM: begin
                    if (nrm_fin) begin
                        if (nrm_zero) begin
                            res_q  <= '1;
                            zero_q <= 1'b1;
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            shcnt_q <= STEP_W'(MAX_STEPS) - nrm_steps;
                            st_q    <= ST_MUL;
                        end
                    end
                end
                ST_MUL: begin
                    if (mul_ready) begin
                        sh_q <= mul_y;
                        st_q <= ST_DENORM;
                    end
                end
                ST_DENORM: begin
                    if (shcnt_q != '0) begin
                        sh_q    <= sh_q >> 1;
                        shcnt_q <= shcnt_q - 1'b1;
                    end else begin
                        res_q  <= sh_q;
                        zero_q <= 1'b0;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: cycles since the accepting edge, used only by the assertions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if ((st_q == ST_IDLE) && start) begin
            lat_q <= '0;
        end else if (st_q != ST_IDLE) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    assign done   = done_q;
    assign zero   = zero_q;
    assign result = res_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R2
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !zero_q |-> (lat_q == LAT_W'(LATENCY))); // R4
    AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && zero_q |-> (lat_q == LAT_W'(1))); // R6
    AST_ZERO_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && zero_q |-> (&res_q)); // R6
    AST_RESULT_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !zero_q |-> (res_q <= (RES_W'(1) << RES_SCALE))
                           && (res_q >= (RES_W'(1) << (RES_SCALE - IN_W / 2)))); // R5

endmodule

// File: tb/sim_irt_inverse_root.sv
// Self-checking bench: accuracy against a real-valued model over a dense
// sweep, plus the exact scaling identities, latency, zero handling, reset
// and start collisions.
module sim_irt_inverse_root;

    localparam int    LAT   = 20;
    localparam real   SCALE = 4194304.0;
    localparam int    WDOG  = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] x_in = '0;
    logic        done;
    logic        zero;
    logic [22:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #4 clk = ~clk;

    irt_inverse_root u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .x_in   (x_in),
        .done   (done),
        .result (result),
        .zero   (zero)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            n_fail++;
            $display("FAIL R2 watchdog expired: actual=%0d expected<%0d", cyc, WDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge where done is seen.
    task automatic run(input logic [15:0] x, input int poke_at, input logic [15:0] poke_x,
                       output logic [22:0] r, output logic z, output int lat);
        start = 1'b1;
        x_in  = x;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        x_in  = ~x;
        lat   = 0;
        while (lat < 60) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (done) break;
            if (lat == poke_at) begin
                start = 1'b1;
                x_in  = poke_x;
            end else begin
                start = 1'b0;
                x_in  = ~x;
            end
        end
        start = 1'b0;
        r = result;
        z = zero;
    endtask

    task automatic check_accuracy(input logic [15:0] x);
        logic [22:0] r;
        logic        z;
        int          lat;
        real         e;
        real         err;
        run(x, 0, '0, r, z, lat);
        e   = SCALE / $sqrt(real'(x));
        err = (real'(r) > e) ? real'(r) - e : e - real'(r);
        check(err <= e / 1024.0, "R5", $sformatf("accuracy x=%0d", x), longint'(r), longint'(e));
        check(lat == LAT, "R4 R11", $sformatf("latency x=%0d", x), lat, LAT);
        check(z == 1'b0, "R8", $sformatf("zero flag x=%0d", x), z, 0);
    endtask

    initial begin
        logic [22:0] r1;
        logic [22:0] r2;
        logic        z;
        int          lat;
        logic [22:0] held;
        bit          seen;

        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        check(result == '0, "R1", "result in reset", result, 0);
        check(zero == 1'b0, "R1", "zero in reset", zero, 0);
        rst_n = 1'b1;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            check(done == 1'b0 && result == '0, "R1", "idle after reset", result, 0);
        end

        // R10 and R3: powers of four normalise to 16384 and come out exact
        for (int j = 0; j < 8; j++) begin
            run(16'(1 << (2 * j)), 0, '0, r1, z, lat);
            check(r1 == 23'(1 << (22 - j)), "R10 R3", $sformatf("power of four j=%0d", j),
                  longint'(r1), longint'(1 << (22 - j)));
        end

        // R6: zero operand, then R8: flag clears on the next nonzero operand
        run(16'd0, 0, '0, r1, z, lat);
        check(z == 1'b1, "R6", "zero flag", z, 1);
        check(r1 == 23'h7FFFFF, "R6", "saturated result", longint'(r1), 8388607);
        check(lat == 1, "R6", "zero latency", lat, 1);
        run(16'd1, 0, '0, r1, z, lat);
        check(z == 1'b0, "R8", "flag after zero", z, 0);
        check(r1 == 23'h400000, "R8", "result after zero", longint'(r1), 4194304);

        // R2: one-cycle pulse and held outputs
        run(16'd2, 0, '0, r1, z, lat);
        held = r1;
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R2", "done width", done, 0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(result == held, "R2", "result held", longint'(result), longint'(held));

        // R7: a start while busy is ignored
        run(16'd16, 5, 16'd1, r1, z, lat);
        check(r1 == 23'd1048576, "R7", "result with intruding start", longint'(r1), 1048576);
        check(lat == LAT, "R7", "latency with intruding start", lat, LAT);
        seen = 1'b0;
        repeat (25) begin
            @(posedge clk);
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        check(!seen, "R7", "no second completion", seen, 0);

        // R9: result(4X) == result(X) >> 1
        for (int x = 1; x <= 16383; x += 83) begin
            run(16'(x), 0, '0, r1, z, lat);
            run(16'(4 * x), 0, '0, r2, z, lat);
            check(r2 == (r1 >> 1), "R9", $sformatf("scaling x=%0d", x),
                  longint'(r2), longint'(r1 >> 1));
        end

        // R5, R4, R11, R8: dense low range, strided upper range, top end
        for (int x = 1; x <= 1500; x++) check_accuracy(16'(x));
        for (int x = 1501; x <= 65535; x += 23) check_accuracy(16'(x));
        check_accuracy(16'hFFFF);
        check_accuracy(16'h4000);
        check_accuracy(16'h3FFF);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule